// File: doc/BRIEF.md
# Indirect Branch Target Cache

This block predicts where an indirect branch will go. It keeps a set-associative store of entries. Each entry holds a valid flag, a partial address tag and a full target address. A fetch-side lookup presents a branch address, the global direction history and the targets of the most recent taken indirect branches. In the same cycle the block answers with a hit flag and the predicted target.

The set is chosen by a hash. The base of the hash is the branch address with its alignment bits removed. The direction history can be folded in, and so can each recent path target, every one shifted by a larger amount. Each fold is switched on by a parameter. When the branch resolves, the update port presents the same address, the history snapshot taken at prediction time, the path targets and the real target. A matching entry has its target refreshed. Otherwise an entry is allocated in a way picked by a free-running pseudo-random sequence. The path history itself lives outside the block and arrives as a packed vector plus a count of valid slots.

Top module: `itc_top`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses with `lk_hit`=0 and `lk_target`=0.
- R2: The hash base is `addr >> SHIFT` (default SHIFT=2), and the set index is the low log2(SETS) bits of the final hash. Address bits below SHIFT do not affect the result.
- R3: With history hashing enabled, the history value is XORed into the hash. History bits at or above log2(SETS) therefore do not change the set.
- R4: With path hashing enabled, slot p (slot 0 is the youngest, in bits p*ADDR_W upward) is XORed in only when p < path count. It is shifted right by SHIFT + p*STEP, where STEP = floor(log2(SETS)) / PATH_LEN in integer division (default 4/2 = 2).
- R5: The tag is the low TAG_W bits of `addr >> SHIFT`. Two addresses that agree in both index and tag are not told apart.
- R6: A hit needs a valid entry whose tag matches. When several ways match, the lowest one supplies the target. A zero tag never hits an empty way.
- R7: A lookup is combinational from the stored state. An update is not visible before the clock edge that captures it, and is visible right after that edge.
- R8: An update whose tag matches a valid way in its set rewrites only that way's target.
- R9: An update that matches nothing writes tag, target and valid into the way given by the low log2(WAYS) bits of an 8-bit sequence register. That register resets to 0x01. On every clock out of reset it shifts left and takes bit7^bit5^bit4^bit3 into bit 0. Each update sets at most one new valid bit, so a set never holds more than WAYS entries.
- R10: In cycles with `up_valid` low the stored entries do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | ADDR_W | Branch address to predict |
| lk_hist | input | HIST_W | Current global direction history |
| lk_path | input | PATH_LEN*ADDR_W | Recent targets, slot 0 youngest |
| lk_path_cnt | input | clog2(PATH_LEN+1) | Number of valid path slots |
| lk_hit | output | 1 | Prediction available |
| lk_target | output | ADDR_W | Predicted target, zero on a miss |
| up_valid | input | 1 | Install or refresh this cycle |
| up_addr | input | ADDR_W | Resolved branch address |
| up_hist | input | HIST_W | History snapshot from prediction time |
| up_path | input | PATH_LEN*ADDR_W | Path targets seen at prediction time |
| up_path_cnt | input | clog2(PATH_LEN+1) | Valid path slots for the update |
| up_target | input | ADDR_W | Resolved target |

## Verification
The bench uses the default build: 16 sets, 4 ways, an 8-bit tag, a 2-bit alignment shift, an 8-bit history and two path slots, with both folds enabled. At these sizes the per-slot step is 2. Small address, history and path values can then move a branch between known sets, show that history bits above the index and slots beyond the count have no effect, and make two addresses alias through the tag width. Five distinct tags aimed at one set overflow its four ways. A reference model that steps the same sequence register predicts which entry is lost.

// File: rtl/itc_pkg.sv
package itc_pkg;

    localparam int         LFSR_W    = 8;
    localparam logic [7:0] LFSR_SEED = 8'h01;

    // maximal-length taps x^8 + x^6 + x^5 + x^4 + 1
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] cur);
        return {cur[LFSR_W-2:0], cur[7] ^ cur[5] ^ cur[4] ^ cur[3]};
    endfunction

    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_REFRESH,
        UPD_ALLOC
    } upd_kind_e;

endpackage

// File: rtl/itc_lfsr.sv
module itc_lfsr
    import itc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] lfsr_o
);

    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_next(lfsr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign lfsr_o = lfsr_q;

endmodule

// File: rtl/itc_hash.sv
module itc_hash #(
    parameter int ADDR_W    = 32,
    parameter int HIST_W    = 8,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 8,
    parameter int SHIFT     = 2,
    parameter int PATH_LEN  = 2,
    parameter int CNT_W     = 2,
    parameter bit HASH_HIST = 1'b1,
    parameter bit HASH_PATH = 1'b1
) (
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [HIST_W-1:0]          hist_i,
    input  logic [PATH_LEN*ADDR_W-1:0] path_i,
    input  logic [CNT_W-1:0]           cnt_i,
    output logic [IDX_W-1:0]           idx_o,
    output logic [TAG_W-1:0]           tag_o
);

    localparam int STEP = IDX_W / PATH_LEN;

    logic [ADDR_W-1:0]               base;
    logic [ADDR_W-1:0]               hist_term;
    logic [PATH_LEN-1:0][ADDR_W-1:0] path_term;
    logic [ADDR_W-1:0]               hash;

    assign base = addr_i >> SHIFT;

    generate
        if (HASH_HIST) begin : g_hist_on
            assign hist_term = ADDR_W'(hist_i);
        end else begin : g_hist_off
            assign hist_term = '0;
        end

        for (genvar p = 0; p < PATH_LEN; p++) begin : g_path
            localparam int SH = SHIFT + p * STEP;
            if (HASH_PATH) begin : g_on
                assign path_term[p] = (CNT_W'(p) < cnt_i) ?
                                      (path_i[p*ADDR_W +: ADDR_W] >> SH) : '0;
            end else begin : g_off
                assign path_term[p] = '0;
            end
        end
    endgenerate

    always_comb begin
        hash = base ^ hist_term;
        for (int p = 0; p < PATH_LEN; p++) begin
            hash = hash ^ path_term[p];
        end
    end

    assign idx_o = hash[IDX_W-1:0];
    assign tag_o = base[TAG_W-1:0];

endmodule

// File: rtl/itc_way_match.sv
module itc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]       vld_i,
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic                  any_o,
    output logic [WAY_W-1:0]      way_o
);

    // walk from the top so the lowest matching way wins
    always_comb begin
        any_o = 1'b0;
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_i[w] && tags_i[w*TAG_W +: TAG_W] == tag_i) begin
                any_o = 1'b1;
                way_o = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/itc_top.sv
module itc_top
    import itc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int TAG_W     = 8,
    parameter int SHIFT     = 2,
    parameter int HIST_W    = 8,
    parameter int PATH_LEN  = 2,
    parameter bit HASH_HIST = 1'b1,
    parameter bit HASH_PATH = 1'b1,
    localparam int IDX_W    = $clog2(SETS),
    localparam int CNT_W    = $clog2(PATH_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          lk_addr,
    input  logic [HIST_W-1:0]          lk_hist,
    input  logic [PATH_LEN*ADDR_W-1:0] lk_path,
    input  logic [CNT_W-1:0]           lk_path_cnt,
    output logic                       lk_hit,
    output logic [ADDR_W-1:0]          lk_target,
    input  logic                       up_valid,
    input  logic [ADDR_W-1:0]          up_addr,
    input  logic [HIST_W-1:0]          up_hist,
    input  logic [PATH_LEN*ADDR_W-1:0] up_path,
    input  logic [CNT_W-1:0]           up_path_cnt,
    input  logic [ADDR_W-1:0]          up_target
);

    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0] tgt;
    } state_t;

    state_t            st_d, st_q;
    upd_kind_e         kind;
    logic [LFSR_W-1:0] lfsr_q;
    logic [WAY_W-1:0]  victim;

    logic [IDX_W-1:0]  lk_set,  up_set;
    logic [TAG_W-1:0]  lk_tag,  up_tag;
    logic              lk_any,  up_any;
    logic [WAY_W-1:0]  lk_way,  up_way;

    itc_hash #(
        .ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .SHIFT(SHIFT), .PATH_LEN(PATH_LEN), .CNT_W(CNT_W),
        .HASH_HIST(HASH_HIST), .HASH_PATH(HASH_PATH)
    ) u_lk_hash (
        .addr_i(lk_addr), .hist_i(lk_hist), .path_i(lk_path),
        .cnt_i(lk_path_cnt), .idx_o(lk_set), .tag_o(lk_tag)
    );

    itc_hash #(
        .ADDR_W(ADDR_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .SHIFT(SHIFT), .PATH_LEN(PATH_LEN), .CNT_W(CNT_W),
        .HASH_HIST(HASH_HIST), .HASH_PATH(HASH_PATH)
    ) u_up_hash (
        .addr_i(up_addr), .hist_i(up_hist), .path_i(up_path),
        .cnt_i(up_path_cnt), .idx_o(up_set), .tag_o(up_tag)
    );

    itc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
        .vld_i(st_q.vld[lk_set]), .tags_i(st_q.tag[lk_set]), .tag_i(lk_tag),
        .any_o(lk_any), .way_o(lk_way)
    );

    itc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_up_match (
        .vld_i(st_q.vld[up_set]), .tags_i(st_q.tag[up_set]), .tag_i(up_tag),
        .any_o(up_any), .way_o(up_way)
    );

    itc_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .lfsr_o(lfsr_q)
    );

    generate
        if (WAYS > 1) begin : g_victim_multi
            assign victim = lfsr_q[WAY_W-1:0];
        end else begin : g_victim_single
            assign victim = '0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        kind = UPD_IDLE;
        if (up_valid) kind = up_any ? UPD_REFRESH : UPD_ALLOC;
        case (kind)
            UPD_REFRESH: begin
                st_d.tgt[up_set][up_way] = up_target;
            end
            UPD_ALLOC: begin
                st_d.vld[up_set][victim] = 1'b1;
                st_d.tag[up_set][victim] = up_tag;
                st_d.tgt[up_set][victim] = up_target;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_hit    = lk_any;
    assign lk_target = lk_any ? st_q.tgt[lk_set][lk_way] : '0;

endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          lk_hit,
    input logic                          up_valid,
    input logic [IDX_W-1:0]              up_set,
    input logic [SETS*WAYS-1:0]          vld_q,
    input logic [SETS*WAYS*TAG_W-1:0]    tag_q,
    input logic [SETS*WAYS*ADDR_W-1:0]   tgt_q,
    input logic [7:0]                    lfsr_q
);

    logic [IDX_W-1:0] last_set_q;
    logic [WAYS-1:0]  last_row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_set_q <= '0;
        else        last_set_q <= up_set;
    end

    assign last_row = vld_q[last_set_q*WAYS +: WAYS];

    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    p_update_fills_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> last_row != '0);

    p_one_new_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> $countones(vld_q ^ $past(vld_q)) <= 1);

    p_seq_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 8'h00);

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(vld_q) && $stable(tag_q) && $stable(tgt_q));

endmodule

bind itc_top itc_checker #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
) u_itc_checker (
    .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .up_valid(up_valid),
    .up_set(up_set), .vld_q(st_q.vld), .tag_q(st_q.tag), .tgt_q(st_q.tgt),
    .lfsr_q(lfsr_q)
);

// File: tb/test_itc_top.sv
`timescale 1ns/1ps
module test_itc_top;

    localparam int AW = 32;
    localparam int NS = 16;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_addr = '0, up_addr = '0, up_target = '0, lk_target;
    logic [7:0]    lk_hist = '0, up_hist = '0;
    logic [63:0]   lk_path = '0, up_path = '0;
    logic [1:0]    lk_path_cnt = '0, up_path_cnt = '0;
    logic          lk_hit, up_valid = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    itc_top i_itc_top (
        .clk(clk), .rst_n(rst_n),
        .lk_addr(lk_addr), .lk_hist(lk_hist), .lk_path(lk_path),
        .lk_path_cnt(lk_path_cnt), .lk_hit(lk_hit), .lk_target(lk_target),
        .up_valid(up_valid), .up_addr(up_addr), .up_hist(up_hist),
        .up_path(up_path), .up_path_cnt(up_path_cnt), .up_target(up_target)
    );

    // ---------------- reference model built from the requirements ----------
    logic          m_vld [NS][NW];
    logic [7:0]    m_tag [NS][NW];
    logic [AW-1:0] m_tgt [NS][NW];
    logic [7:0]    m_seq;

    function automatic logic [3:0] f_set(logic [31:0] a, logic [7:0] h,
                                         logic [63:0] pth, logic [1:0] c);
        logic [31:0] x;
        x = (a >> 2) ^ {24'h0, h};
        if (c > 0) x = x ^ (pth[31:0] >> 2);
        if (c > 1) x = x ^ (pth[63:32] >> 4);
        return x[3:0];
    endfunction

    function automatic logic [7:0] f_tag(logic [31:0] a);
        logic [31:0] x;
        x = a >> 2;
        return x[7:0];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) begin
                    m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_tgt[s][w] = '0;
                end
            m_seq = 8'h01;
        end else begin
            if (up_valid) begin
                logic [3:0] s;
                logic [7:0] t;
                bit found;
                s = f_set(up_addr, up_hist, up_path, up_path_cnt);
                t = f_tag(up_addr);
                found = 1'b0;
                for (int w = 0; w < NW; w++)
                    if (!found && m_vld[s][w] && m_tag[s][w] == t) begin
                        m_tgt[s][w] = up_target; found = 1'b1;
                    end
                if (!found) begin
                    m_vld[s][m_seq[1:0]] = 1'b1;
                    m_tag[s][m_seq[1:0]] = t;
                    m_tgt[s][m_seq[1:0]] = up_target;
                end
            end
            m_seq = {m_seq[6:0], m_seq[7] ^ m_seq[5] ^ m_seq[4] ^ m_seq[3]};
        end
    end

    task automatic m_lookup(output bit hit, output logic [31:0] tgt);
        logic [3:0] s;
        logic [7:0] t;
        s = f_set(lk_addr, lk_hist, lk_path, lk_path_cnt);
        t = f_tag(lk_addr);
        hit = 1'b0; tgt = '0;
        for (int w = 0; w < NW; w++)
            if (!hit && m_vld[s][w] && m_tag[s][w] == t) begin
                hit = 1'b1; tgt = m_tgt[s][w];
            end
    endtask

    // ---------------- helpers ---------------------------------------------
    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [7:0] h,
                         input logic [31:0] p0, input logic [31:0] p1,
                         input logic [1:0] c, input logic [31:0] t);
        lk_addr = a; lk_hist = h; lk_path = {p1, p0}; lk_path_cnt = c;
        up_addr = a; up_hist = h; up_path = {p1, p0}; up_path_cnt = c;
        up_target = t;
    endtask

    task automatic upd(input logic [31:0] a, input logic [7:0] h, input logic [31:0] t);
        @(negedge clk);
        drive(a, h, 32'h0, 32'h0, 2'd0, t);
        up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic look_model(input logic [31:0] a, input logic [7:0] h, input string req);
        bit          eh;
        logic [31:0] et;
        @(negedge clk);
        drive(a, h, 32'h0, 32'h0, 2'd0, 32'h0);
        #1;
        m_lookup(eh, et);
        chk(lk_hit == eh, {req, " hit"}, 32'(lk_hit), 32'(eh));
        chk(lk_target == et, {req, " target"}, lk_target, et);
    endtask

    // ---------------- vector table ----------------------------------------
    typedef struct packed {
        logic        upd;
        logic [31:0] addr;
        logic [7:0]  hist;
        logic [31:0] p0;
        logic [31:0] p1;
        logic [1:0]  cnt;
        logic [31:0] tgt;
        logic        exp_hit;
        logic [31:0] exp_tgt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 32'h000, 8'h00, 32'h0, 32'h00, 2'd0, 32'h0,         1'b0, 32'h0,         4'd6},  // R6 zero tag, empty
        '{1'b0, 32'h100, 8'h00, 32'h0, 32'h00, 2'd0, 32'h0,         1'b0, 32'h0,         4'd1},  // R1 empty
        '{1'b1, 32'h100, 8'h00, 32'h0, 32'h00, 2'd0, 32'hAAAA0000,  1'b0, 32'h0,         4'd9},  // allocate set0
        '{1'b0, 32'h100, 8'h00, 32'h0, 32'h00, 2'd0, 32'h0,         1'b1, 32'hAAAA0000,  4'd7},  // R7
        '{1'b0, 32'h101, 8'h00, 32'h0, 32'h00, 2'd0, 32'h0,         1'b1, 32'hAAAA0000,  4'd2},  // R2 low bits
        '{1'b0, 32'h100, 8'h01, 32'h0, 32'h00, 2'd0, 32'h0,         1'b0, 32'h0,         4'd3},  // R3 set1
        '{1'b0, 32'h100, 8'h10, 32'h0, 32'h00, 2'd0, 32'h0,         1'b1, 32'hAAAA0000,  4'd3},  // R3 high history
        '{1'b1, 32'h100, 8'h00, 32'h4, 32'h00, 2'd1, 32'hBBBB0000,  1'b0, 32'h0,         4'd4},  // allocate set1
        '{1'b0, 32'h100, 8'h00, 32'h4, 32'h00, 2'd1, 32'h0,         1'b1, 32'hBBBB0000,  4'd4},  // R4 slot0
        '{1'b0, 32'h100, 8'h01, 32'h0, 32'h00, 2'd0, 32'h0,         1'b1, 32'hBBBB0000,  4'd3},  // R3 same set
        '{1'b0, 32'h100, 8'h00, 32'h4, 32'h10, 2'd2, 32'h0,         1'b1, 32'hAAAA0000,  4'd4},  // R4 slot1 >>4
        '{1'b0, 32'h100, 8'h00, 32'h4, 32'h10, 2'd1, 32'h0,         1'b1, 32'hBBBB0000,  4'd4},  // R4 count
        '{1'b1, 32'h100, 8'h00, 32'h0, 32'h00, 2'd0, 32'hCCCC0000,  1'b0, 32'h0,         4'd8},  // refresh set0
        '{1'b0, 32'h100, 8'h00, 32'h0, 32'h00, 2'd0, 32'h0,         1'b1, 32'hCCCC0000,  4'd8},  // R8
        '{1'b0, 32'h500, 8'h00, 32'h0, 32'h00, 2'd0, 32'h0,         1'b1, 32'hCCCC0000,  4'd5},  // R5 alias
        '{1'b0, 32'h104, 8'h00, 32'h0, 32'h00, 2'd0, 32'h0,         1'b0, 32'h0,         4'd5}   // R5 other tag
    };

    initial begin
        #(1ms);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hits;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        drive(32'h100, 8'h00, 32'h0, 32'h0, 2'd0, 32'h0);
        #1;
        chk(lk_hit == 1'b0, "R1 reset hit", 32'(lk_hit), 32'h0);
        chk(lk_target == 32'h0, "R1 reset target", lk_target, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].addr, TBL[i].hist, TBL[i].p0, TBL[i].p1, TBL[i].cnt, TBL[i].tgt);
            if (TBL[i].upd) begin
                up_valid = 1'b1;
                @(negedge clk);
                up_valid = 1'b0;
            end else begin
                #1;
                chk(lk_hit == TBL[i].exp_hit, $sformatf("R%0d vec%0d hit", TBL[i].req, i),
                    32'(lk_hit), 32'(TBL[i].exp_hit));
                chk(lk_target == TBL[i].exp_tgt, $sformatf("R%0d vec%0d target", TBL[i].req, i),
                    lk_target, TBL[i].exp_tgt);
            end
        end

        // R7: update invisible before its edge, visible after
        @(negedge clk);
        drive(32'h24, 8'h00, 32'h0, 32'h0, 2'd0, 32'h12340000);
        up_valid = 1'b1;
        #1;
        chk(lk_hit == 1'b0, "R7 before edge", 32'(lk_hit), 32'h0);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        chk(lk_hit == 1'b1, "R7 after edge hit", 32'(lk_hit), 32'h1);
        chk(lk_target == 32'h12340000, "R7 after edge target", lk_target, 32'h12340000);

        // R9: five distinct tags into set 5 overflow four ways
        for (int k = 0; k < 5; k++) upd((32'h5 + 32'(k) * 32'h10) << 2, 8'h00, 32'hD000 + 32'(k));
        hits = 0;
        for (int k = 0; k < 5; k++) begin
            look_model((32'h5 + 32'(k) * 32'h10) << 2, 8'h00, "R9 victim");
            hits += int'(lk_hit);
        end
        chk(hits == NW, "R9 set capacity", 32'(hits), 32'(NW));

        // R8: refresh inside a full set
        for (int k = 0; k < 5; k++) upd((32'h5 + 32'(k) * 32'h10) << 2, 8'h00, 32'hE000 + 32'(k));
        for (int k = 0; k < 5; k++) look_model((32'h5 + 32'(k) * 32'h10) << 2, 8'h00, "R8 refresh");

        // R10: idle cycles leave contents alone
        repeat (30) @(negedge clk);
        for (int k = 0; k < 5; k++) look_model((32'h5 + 32'(k) * 32'h10) << 2, 8'h00, "R10 idle");
        look_model(32'h100, 8'h00, "R10 set0");
        chk(lk_target == 32'hCCCC0000, "R10 set0 value", lk_target, 32'hCCCC0000);

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(32'h100, 8'h00, 32'h0, 32'h0, 2'd0, 32'h0);
        #1;
        chk(lk_hit == 1'b0, "R1 re-reset hit", 32'(lk_hit), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule